// File: doc/BRIEF.md
# Recirculating Parallel-In Serial-Out Shift Register

This block holds a 16-bit word that can be filled in parallel from a data bus or one bit at a time through a serial port, and read back through the same serial port. The port is split into a serial input, a registered serial output and a registered output-enable, so a pad or an on-chip bus can share one wire in both directions.

A two-bit mode input picks one of four operations on each rising clock edge. The operations are hold, serial write, serial read and parallel load. During a read the bit leaving the top end of the register is fed back into the bottom end. Sixteen reads therefore stream the word out most significant bit first and leave it unchanged. An active-low select input acts as a synchronous enable. While it is high the block behaves exactly as in hold, whatever the mode input says, so toggling the select alone never shifts the word.

Top module: `rcirc_piso`

## Requirements
- R1: A synchronous active-high reset clears the stored word to zero and drives `ser_oe` and `ser_out` low on the edge where it is sampled.
- R2: With `sel_n` low and `mode` = 2'b11 (load), the stored word takes the value of `par_in` at the clock edge. `ser_oe` is low in the following cycle.
- R3: With `sel_n` low and `mode` = 2'b10 (read), the word rotates one place toward bit 15 and old bit 15 enters bit 0. In the following cycle `ser_oe` is high and `ser_out` equals old bit 15.
- R4: Sixteen consecutive read edges put the stored word on `ser_out` most significant bit first, one bit per cycle. After those edges the stored word equals its value before the first read.
- R5: With `sel_n` low and `mode` = 2'b01 (write), the word shifts one place toward bit 15 and `ser_in` enters bit 0. `ser_oe` is low in the following cycle. Sixteen writes therefore leave the first written bit in bit 15.
- R6: With `sel_n` low and `mode` = 2'b00 (hold), the stored word is unchanged and `ser_oe` is low in the following cycle.
- R7: While `sel_n` is high, every mode value acts as hold: no load, no write, no rotation, and `ser_oe` low. Toggling `sel_n` during a read sequence only pauses the sequence.
- R8: `ser_out` is low in every cycle in which `ser_oe` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| sel_n | input | 1 | Select, active low; high forces hold |
| mode | input | 2 | 00 hold, 01 serial write, 10 serial read, 11 parallel load |
| par_in | input | WIDTH | Parallel load data |
| ser_in | input | 1 | Serial data entering bit 0 in write mode |
| ser_out | output | 1 | Registered serial data, bit leaving bit 15 on a read |
| ser_oe | output | 1 | Registered enable for driving the serial wire |

## Verification
Every result appears exactly one edge after the inputs that cause it. The stored word changes on the edge, and `ser_out` and `ser_oe` are registered from that same edge. The bench drives inputs on the falling edge. At that moment it pushes the expected port values for the next rising edge into a queue. A monitor pops one item 2 ns after each rising edge, so every comparison falls in the cycle the result is due. The stored word is observed only through a following sixteen-cycle read, and its expected serial stream is queued one bit per cycle in the same way.

// File: rtl/rcirc_pkg.sv
package rcirc_pkg;

  typedef enum logic [1:0] {
    MODE_HOLD  = 2'b00,
    MODE_WRITE = 2'b01,
    MODE_READ  = 2'b10,
    MODE_LOAD  = 2'b11
  } mode_e;

endpackage

// File: rtl/rcirc_ctrl.sv
module rcirc_ctrl
  import rcirc_pkg::*;
(
  input  logic       sel_n,
  input  logic [1:0] mode,
  output mode_e      eff_mode
);

  // Deselect is a synchronous enable: it simply collapses the mode to hold.
  always_comb begin
    if (sel_n) eff_mode = MODE_HOLD;
    else       eff_mode = mode_e'(mode);
  end

endmodule

// File: rtl/rcirc_core.sv
module rcirc_core
  import rcirc_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  mode_e            eff_mode,
  input  logic [WIDTH-1:0] par_in,
  input  logic             ser_in,
  output logic [WIDTH-1:0] word,
  output logic             msb
);

  localparam int TOP = WIDTH - 1;

  logic [WIDTH-1:0] nxt;
  logic             feed;

  // Bit entering position 0: external data when writing, the top bit when reading.
  assign feed = (eff_mode == MODE_READ) ? word[TOP] : ser_in;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic below;
    if (i == 0) begin : g_low
      assign below = feed;
    end else begin : g_up
      assign below = word[i-1];
    end

    always_comb begin
      unique case (eff_mode)
        MODE_LOAD:             nxt[i] = par_in[i];
        MODE_WRITE, MODE_READ: nxt[i] = below;
        default:               nxt[i] = word[i];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) word <= '0;
    else     word <= nxt;
  end

  assign msb = word[TOP];

endmodule

// File: rtl/rcirc_port.sv
module rcirc_port
  import rcirc_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  mode_e eff_mode,
  input  logic  msb,
  output logic  ser_out,
  output logic  ser_oe
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ser_oe  <= 1'b0;
      ser_out <= 1'b0;
    end else begin
      ser_oe  <= (eff_mode == MODE_READ);
      ser_out <= (eff_mode == MODE_READ) & msb;
    end
  end

endmodule

// File: rtl/rcirc_piso.sv
module rcirc_piso
  import rcirc_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel_n,
  input  logic [1:0]       mode,
  input  logic [WIDTH-1:0] par_in,
  input  logic             ser_in,
  output logic             ser_out,
  output logic             ser_oe
);

  mode_e            eff_mode;
  logic [WIDTH-1:0] word_q;
  logic             msb;

  rcirc_ctrl u_ctrl (
    .sel_n    (sel_n),
    .mode     (mode),
    .eff_mode (eff_mode)
  );

  rcirc_core #(.WIDTH(WIDTH)) u_core (
    .clk      (clk),
    .rst      (rst),
    .eff_mode (eff_mode),
    .par_in   (par_in),
    .ser_in   (ser_in),
    .word     (word_q),
    .msb      (msb)
  );

  rcirc_port u_port (
    .clk      (clk),
    .rst      (rst),
    .eff_mode (eff_mode),
    .msb      (msb),
    .ser_out  (ser_out),
    .ser_oe   (ser_oe)
  );

endmodule

// File: rtl/rcirc_chk.sv
module rcirc_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             sel_n,
  input logic [1:0]       mode,
  input logic [WIDTH-1:0] par_in,
  input logic             ser_in,
  input logic [WIDTH-1:0] word,
  input logic             ser_out,
  input logic             ser_oe
);

  logic rst_d = 1'b0;

  always_ff @(posedge clk) rst_d <= rst;

  // R1: one edge after a sampled reset the port is quiet and the word is zero
  always_ff @(posedge clk) begin
    if (rst_d) begin
      p_reset_r1: assert (!ser_oe && !ser_out && word == '0)
        else $error("p_reset_r1");
    end
  end

  p_load_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(sel_n) && $past(mode) == 2'b11)
      |-> (word == $past(par_in) && !ser_oe));

  p_rotate_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(sel_n) && $past(mode) == 2'b10)
      |-> (word == {$past(word[WIDTH-2:0]), $past(word[WIDTH-1])}
           && ser_oe && ser_out == $past(word[WIDTH-1])));

  p_write_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(sel_n) && $past(mode) == 2'b01)
      |-> (word == {$past(word[WIDTH-2:0]), $past(ser_in)} && !ser_oe));

  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(sel_n) && $past(mode) == 2'b00)
      |-> (word == $past(word) && !ser_oe));

  p_deselect_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(sel_n)) |-> (word == $past(word) && !ser_oe));

  p_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !ser_oe |-> !ser_out);

endmodule

bind rcirc_piso rcirc_chk #(.WIDTH(WIDTH)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .sel_n   (sel_n),
  .mode    (mode),
  .par_in  (par_in),
  .ser_in  (ser_in),
  .word    (word_q),
  .ser_out (ser_out),
  .ser_oe  (ser_oe)
);

// File: tb/test_rcirc_piso.sv
`timescale 1ns/1ps
module test_rcirc_piso;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         sel_n = 1'b1;
  logic [1:0]   mode = 2'b00;
  logic [W-1:0] par_in = '0;
  logic         ser_in = 1'b0;
  logic         ser_out, ser_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic  oe;
    logic  dout;
    string req;
  } item_t;

  item_t        sb[$];
  logic [W-1:0] model = '0;

  always #4 clk = ~clk;

  rcirc_piso #(.WIDTH(W)) i_rcirc_piso (
    .clk(clk), .rst(rst), .sel_n(sel_n), .mode(mode),
    .par_in(par_in), .ser_in(ser_in), .ser_out(ser_out), .ser_oe(ser_oe)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // Driver: applies one cycle of stimulus and queues the port values due after the edge.
  task automatic step(input logic sn, input logic [1:0] m, input logic [W-1:0] p,
                      input logic si, input string req);
    item_t it;
    logic [1:0] em;
    @(negedge clk);
    sel_n = sn; mode = m; par_in = p; ser_in = si;
    em = sn ? 2'b00 : m;
    it.oe   = (em == 2'b10);
    it.dout = (em == 2'b10) ? model[W-1] : 1'b0;
    it.req  = req;
    case (em)
      2'b01: model = {model[W-2:0], si};
      2'b10: model = {model[W-2:0], model[W-1]};
      2'b11: model = p;
      default: ;
    endcase
    sb.push_back(it);
  endtask

  task automatic read_word(input string req);
    for (int k = 0; k < W; k++) step(1'b0, 2'b10, '0, 1'b0, req);
  endtask

  // Monitor: one expected item per rising edge, compared 2 ns later.
  always @(posedge clk) begin
    #2;
    if (sb.size() != 0) begin
      item_t it;
      it = sb.pop_front();
      check(it.req, {{(W-2){1'b0}}, ser_oe, ser_out}, {{(W-2){1'b0}}, it.oe, it.dout});
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; sel_n = 1'b1; mode = 2'b00;
    model = '0;
    @(posedge clk); #2;
    // R1: port quiet after reset edge
    check("R1", {{(W-2){1'b0}}, ser_oe, ser_out}, '0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #(8 * 20000);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [W-1:0] wr;
    repeat (3) @(posedge clk);
    #2;
    check("R1", {{(W-2){1'b0}}, ser_oe, ser_out}, '0);
    @(negedge clk);
    rst = 1'b0;

    // R2 load, then R4 stream out twice: second pass proves preservation
    step(1'b0, 2'b11, 16'hA5C3, 1'b0, "R2");
    read_word("R4");
    read_word("R4");

    // R5 serial write of a word, first bit written ends in bit 15
    wr = 16'h3C96;
    for (int k = W - 1; k >= 0; k--) step(1'b0, 2'b01, 16'hFFFF, wr[k], "R5");
    read_word("R5");

    // R6 hold keeps the word; R8 port quiet meanwhile
    for (int k = 0; k < 5; k++) step(1'b0, 2'b00, 16'h1234, 1'b1, "R8");
    read_word("R6");

    // R7 deselect overrides load, write and read
    step(1'b1, 2'b11, 16'hFFFF, 1'b1, "R7");
    step(1'b1, 2'b01, 16'h0000, 1'b1, "R7");
    step(1'b1, 2'b10, 16'h0000, 1'b0, "R7");
    read_word("R7");

    // R7 select toggled during a read only pauses it
    for (int k = 0; k < W; k++) begin
      step(1'b0, 2'b10, '0, 1'b0, "R7");
      if (k % 4 == 1) step(1'b1, 2'b10, '0, 1'b0, "R7");
    end
    read_word("R4");

    // R3 partial read, then reload and read a sparse word
    for (int k = 0; k < 5; k++) step(1'b0, 2'b10, '0, 1'b0, "R3");
    step(1'b0, 2'b11, 16'h0001, 1'b0, "R2");
    read_word("R3");
    step(1'b0, 2'b11, 16'h8000, 1'b0, "R2");
    read_word("R3");

    // R1 reset clears the stored word
    step(1'b0, 2'b11, 16'hFFFF, 1'b0, "R2");
    wait (sb.size() == 0);
    do_reset();
    read_word("R1");

    wait (sb.size() == 0);
    @(posedge clk); #3;
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule